// File: doc/BRIEF.md
# Saturating Rounding Narrow-Interleave Shifter

This datapath block takes four signed source vectors of equal length and a 7-bit shift code, and returns one destination vector of the same length. Each source element goes through three steps. A rounding bias is added to it. It is then shifted right arithmetically. Finally it is clamped to a signed element one quarter of its width. The narrowed elements from the four sources are woven together lane by lane, so that element `e` of source `i` lands in destination lane `4*e + i`. Every lane is written on every operation.

The shift code is a 2-bit size field placed above a 5-bit immediate. The size field selects one of two modes. Byte mode turns 32-bit sources into 8-bit lanes. Halfword mode turns 64-bit sources into 16-bit lanes. The size field also sets, together with the immediate, the shift distance. A size field of zero is reserved: the block raises an illegal flag and forces the destination to zero.

The block has one register stage by default. Operands are captured on an `in_valid` pulse, and the result appears with `out_valid` one cycle later. A parameter removes the stage and leaves a purely combinational path. A single saturation bit reports whether any lane was clamped in the current operation.

Top module: `srn_narrow_interleave`

## Requirements
- R1: A size field of 2'b00 is illegal. The result then has `illegal`=1, `dst` all zeros and `sat`=0, whatever the sources hold.
- R2: A size field of 2'b01 selects byte mode, with 32-bit source elements and 8-bit lanes. The shift distance is 32 minus the immediate, which gives the range 1 to 32.
- R3: A size field of 2'b10 or 2'b11 selects halfword mode, with 64-bit source elements and 16-bit lanes. The shift distance is 128 minus the unsigned 7-bit value {size, imm}. This gives 33 to 64 for 2'b10 and 1 to 32 for 2'b11.
- R4: Before the shift, 2^(shift-1) is added to the sign-extended source element, in a width that cannot overflow. For example, the most positive 32-bit input shifted by 1 rounds to 2^30 and does not wrap.
- R5: The shift is arithmetic: negative rounded values keep their sign. For example, -9 shifted by 4 gives -1.
- R6: Each shifted value is clamped to [-2^(N-1), 2^(N-1)-1], where N is the lane width. A value that reaches the bound only after rounding is clamped as well.
- R7: Element e of source i goes to destination lane 4*e+i. Lane k occupies bits [k*N +: N] of `dst`.
- R8: `sat` is the OR of the per-lane clamp events of the current operation.
- R9: In the registered variant, `out_valid` is high exactly in the cycle after an `in_valid` cycle. `dst`, `illegal` and `sat` change only after an `in_valid` cycle.
- R10: A synchronous active-high `rst` clears `out_valid`, `dst`, `illegal` and `sat`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| src0 | input | VL | Source vector 0 |
| src1 | input | VL | Source vector 1 |
| src2 | input | VL | Source vector 2 |
| src3 | input | VL | Source vector 3 |
| size_fld | input | 2 | Size field (upper bits of shift code) |
| imm_fld | input | 5 | Immediate (lower bits of shift code) |
| out_valid | output | 1 | Result valid |
| dst | output | VL | Narrowed, interleaved destination vector |
| illegal | output | 1 | Reserved size field was used |
| sat | output | 1 | At least one lane clamped |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the one-cycle valid latency;
- that the outputs hold while no operation is issued;
- that an illegal code always yields a zero vector with no saturation;
- that the decoded shift distance stays inside the legal window for each mode.

The arithmetic can only be shown by the bench's scenarios. This covers the exact rounded and clamped lane values, the cases where rounding pushes a value across the clamp bound, the largest and smallest shifts, and the extreme inputs. The lane ordering of the interleave also needs the bench, through distinct per-element values, as does a saturation flag raised by one lane among many.

// File: rtl/srn_pkg.sv
`timescale 1ns/1ps
package srn_pkg;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_HALF = 1'b1
    } width_mode_e;

    typedef struct packed {
        logic        illegal;
        width_mode_e mode;
        logic [6:0]  shift;
    } shift_dec_t;

    localparam int BYTE_SRC_W = 32;
    localparam int BYTE_DST_W = 8;
    localparam int HALF_SRC_W = 64;
    localparam int HALF_DST_W = 16;

    // Shift distance = 8*lane_width - {size, imm}
    function automatic shift_dec_t decode_shift(input logic [1:0] sz, input logic [4:0] imm);
        shift_dec_t d;
        logic [7:0] code;
        code      = {1'b0, sz, imm};
        d.illegal = (sz == 2'b00);
        d.mode    = sz[1] ? MODE_HALF : MODE_BYTE;
        if (sz[1])
            d.shift = 7'(8'd128 - code);
        else
            d.shift = 7'(8'd64 - code);
        return d;
    endfunction

endpackage

// File: rtl/srn_decode.sv
`timescale 1ns/1ps
module srn_decode
    import srn_pkg::*;
(
    input  logic [1:0] size_fld,
    input  logic [4:0] imm_fld,
    output shift_dec_t dec
);
    always_comb dec = decode_shift(size_fld, imm_fld);
endmodule

// File: rtl/srn_lane.sv
`timescale 1ns/1ps
module srn_lane #(
    parameter int SRC_W = 32,
    parameter int DST_W = 8
) (
    input  logic [SRC_W-1:0] elem,
    input  logic [6:0]       shift,
    output logic [DST_W-1:0] res,
    output logic             sat
);
    localparam int EXT_W = SRC_W + 1;
    localparam logic signed [EXT_W-1:0] MAXV = EXT_W'((64'sd1 <<< (DST_W - 1)) - 64'sd1);
    localparam logic signed [EXT_W-1:0] MINV = ~MAXV;

    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] rnd;
    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] shr;

    always_comb begin
        ext = {elem[SRC_W-1], elem};
        rnd = (shift == 7'd0) ? '0 : (EXT_W'(1) << (shift - 7'd1));
        sum = ext + rnd;
        shr = sum >>> shift;
        if (shr > MAXV) begin
            res = MAXV[DST_W-1:0];
            sat = 1'b1;
        end else if (shr < MINV) begin
            res = MINV[DST_W-1:0];
            sat = 1'b1;
        end else begin
            res = shr[DST_W-1:0];
            sat = 1'b0;
        end
    end
endmodule

// File: rtl/srn_narrow_array.sv
`timescale 1ns/1ps
module srn_narrow_array #(
    parameter int VL    = 128,
    parameter int SRC_W = 32,
    parameter int DST_W = 8
) (
    input  logic [3:0][VL-1:0] srcs,
    input  logic [6:0]         shift,
    output logic [VL-1:0]      dst,
    output logic               sat_any
);
    localparam int ELEMS = VL / SRC_W;
    localparam int LANES = 4 * ELEMS;

    logic [LANES-1:0] sat_vec;

    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
        for (genvar i = 0; i < 4; i++) begin : g_src
            srn_lane #(.SRC_W(SRC_W), .DST_W(DST_W)) u_lane (
                .elem  (srcs[i][e*SRC_W +: SRC_W]),
                .shift (shift),
                .res   (dst[(4*e+i)*DST_W +: DST_W]),
                .sat   (sat_vec[4*e+i])
            );
        end
    end

    assign sat_any = |sat_vec;
endmodule

// File: rtl/srn_narrow_interleave.sv
`timescale 1ns/1ps
module srn_narrow_interleave
    import srn_pkg::*;
#(
    parameter int VL         = 128,
    parameter bit REGISTERED = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [VL-1:0] src0,
    input  logic [VL-1:0] src1,
    input  logic [VL-1:0] src2,
    input  logic [VL-1:0] src3,
    input  logic [1:0]    size_fld,
    input  logic [4:0]    imm_fld,
    output logic          out_valid,
    output logic [VL-1:0] dst,
    output logic          illegal,
    output logic          sat
);
    localparam int GROUPS64 = VL / 64;

    shift_dec_t         dec;
    logic [6:0]         dec_shift;
    logic [3:0][VL-1:0] srcs;
    logic [VL-1:0]      dst_byte, dst_half, nxt_dst;
    logic               sat_byte, sat_half, nxt_sat;

    srn_decode u_dec (
        .size_fld (size_fld),
        .imm_fld  (imm_fld),
        .dec      (dec)
    );

    assign dec_shift = dec.shift;
    assign srcs      = {src3, src2, src1, src0};

    srn_narrow_array #(.VL(GROUPS64 * 64), .SRC_W(BYTE_SRC_W), .DST_W(BYTE_DST_W)) u_byte (
        .srcs    (srcs),
        .shift   (dec.shift),
        .dst     (dst_byte),
        .sat_any (sat_byte)
    );

    srn_narrow_array #(.VL(GROUPS64 * 64), .SRC_W(HALF_SRC_W), .DST_W(HALF_DST_W)) u_half (
        .srcs    (srcs),
        .shift   (dec.shift),
        .dst     (dst_half),
        .sat_any (sat_half)
    );

    always_comb begin
        if (dec.illegal) begin
            nxt_dst = '0;
            nxt_sat = 1'b0;
        end else if (dec.mode == MODE_HALF) begin
            nxt_dst = dst_half;
            nxt_sat = sat_half;
        end else begin
            nxt_dst = dst_byte;
            nxt_sat = sat_byte;
        end
    end

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                dst       <= '0;
                illegal   <= 1'b0;
                sat       <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    dst     <= nxt_dst;
                    illegal <= dec.illegal;
                    sat     <= nxt_sat;
                end
            end
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign dst       = nxt_dst;
        assign illegal   = dec.illegal;
        assign sat       = nxt_sat;
    end
endmodule

// File: rtl/srn_narrow_interleave_chk.sv
`timescale 1ns/1ps
module srn_narrow_interleave_chk #(
    parameter int VL         = 128,
    parameter bit REGISTERED = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [1:0]    size_fld,
    input logic [6:0]    dec_shift,
    input logic          out_valid,
    input logic [VL-1:0] dst,
    input logic          illegal,
    input logic          sat
);
    p_illegal_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> (dst == '0 && !sat));

    p_shift_range_r2: assert property (@(posedge clk) disable iff (rst)
        (size_fld == 2'b01) |-> (dec_shift >= 7'd1 && dec_shift <= 7'd32));

    p_shift_range_r3: assert property (@(posedge clk) disable iff (rst)
        size_fld[1] |-> (dec_shift >= 7'd1 && dec_shift <= 7'd64));

    if (REGISTERED) begin : g_seq
        p_latency_r9: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);

        p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);

        p_hold_r9: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> ($stable(dst) && $stable(illegal) && $stable(sat)));

        p_illegal_flag_r1: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (illegal == ($past(size_fld) == 2'b00)));
    end
endmodule

bind srn_narrow_interleave srn_narrow_interleave_chk #(.VL(VL), .REGISTERED(REGISTERED)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .size_fld  (size_fld),
    .dec_shift (dec_shift),
    .out_valid (out_valid),
    .dst       (dst),
    .illegal   (illegal),
    .sat       (sat)
);

// File: tb/srn_narrow_interleave_bench.sv
`timescale 1ns/1ps
module srn_narrow_interleave_bench;
    localparam int VL = 128;

    typedef struct packed {
        logic [1:0]  sz;
        logic [4:0]  imm;
        logic [63:0] x;
        logic [15:0] exp;
        logic        esat;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{2'b01, 5'd31, 64'h5,                 16'h0003, 1'b0},
        '{2'b01, 5'd31, 64'hFFFFFFFB,          16'h00FE, 1'b0},
        '{2'b01, 5'd0,  64'h7FFFFFFF,          16'h0000, 1'b0},
        '{2'b01, 5'd0,  64'h80000000,          16'h0000, 1'b0},
        '{2'b01, 5'd8,  64'h7F800000,          16'h007F, 1'b1},
        '{2'b01, 5'd8,  64'h7F7FFFFF,          16'h007F, 1'b0},
        '{2'b01, 5'd8,  64'h807FFFFF,          16'h0080, 1'b0},
        '{2'b01, 5'd31, 64'h7FFFFFFF,          16'h007F, 1'b1},
        '{2'b01, 5'd31, 64'h80000000,          16'h0080, 1'b1},
        '{2'b01, 5'd28, 64'hFFFFFFF7,          16'h00FF, 1'b0},
        '{2'b10, 5'd0,  64'h7FFFFFFFFFFFFFFF,  16'h0000, 1'b0},
        '{2'b10, 5'd31, 64'h100000000,         16'h0001, 1'b0},
        '{2'b11, 5'd31, 64'hFFFD,              16'h7FFF, 1'b0},
        '{2'b11, 5'd31, 64'hFFFF,              16'h7FFF, 1'b1},
        '{2'b11, 5'd0,  64'hFFFF7FFF7FFFFFFF,  16'h8000, 1'b1},
        '{2'b10, 5'd31, 64'h8000000000000000,  16'h8000, 1'b1},
        '{2'b10, 5'd0,  64'h8000000000000000,  16'h0000, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [VL-1:0] s0 = '0, s1 = '0, s2 = '0, s3 = '0;
    logic [1:0]    size_fld = 2'b01;
    logic [4:0]    imm_fld = 5'd0;
    logic          out_valid;
    logic [VL-1:0] dst;
    logic          illegal;
    logic          sat;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    srn_narrow_interleave u_srn_narrow_interleave (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .src0(s0), .src1(s1), .src2(s2), .src3(s3),
        .size_fld(size_fld), .imm_fld(imm_fld),
        .out_valid(out_valid), .dst(dst), .illegal(illegal), .sat(sat)
    );

    task automatic check(input bit ok, input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic signed [63:0] x, input int sh, input int n, output logic s);
        logic signed [66:0] v;
        logic signed [66:0] mx;
        v  = x;
        v  = v + (67'sd1 <<< (sh - 1));
        v  = v >>> sh;
        mx = (67'sd1 <<< (n - 1)) - 67'sd1;
        s  = 1'b0;
        if (v > mx) begin v = mx; s = 1'b1; end
        else if (v < -mx - 67'sd1) begin v = -mx - 67'sd1; s = 1'b1; end
        return 16'(v) & 16'((32'd1 << n) - 1);
    endfunction

    task automatic apply();
        @(negedge clk) in_valid = 1'b1;
        @(negedge clk) in_valid = 1'b0;
    endtask

    task automatic fill_all(input logic [63:0] x, input bit half);
        for (int k = 0; k < VL / 32; k++) begin
            if (half) begin
                if (k % 2 == 0) begin
                    s0[k*32 +: 64] = x; s1[k*32 +: 64] = x;
                    s2[k*32 +: 64] = x; s3[k*32 +: 64] = x;
                end
            end else begin
                s0[k*32 +: 32] = x[31:0]; s1[k*32 +: 32] = x[31:0];
                s2[k*32 +: 32] = x[31:0]; s3[k*32 +: 32] = x[31:0];
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VL-1:0] expv;
        logic          es, ls;
        logic [VL-1:0] held;

        // R10: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && dst == '0 && illegal == 1'b0 && sat == 1'b0,
              "R10 reset", {dst[VL-4:0], out_valid, illegal, sat}, '0);
        rst = 1'b0;

        // Table walk: R2 R3 R4 R5 R6
        for (int t = 0; t < NV; t++) begin
            bit half;
            int nw;
            half = TBL[t].sz[1];
            nw   = half ? 16 : 8;
            size_fld = TBL[t].sz;
            imm_fld  = TBL[t].imm;
            fill_all(TBL[t].x, half);
            apply();
            expv = '0;
            for (int k = 0; k < VL / nw; k++) begin
                if (half) expv[k*16 +: 16] = TBL[t].exp;
                else      expv[k*8 +: 8]   = TBL[t].exp[7:0];
            end
            check(out_valid == 1'b1 && dst == expv,
                  half ? "R3 R4 R5 R6 halfword vector" : "R2 R4 R5 R6 byte vector", dst, expv);
            check(sat == TBL[t].esat && illegal == 1'b0, "R6 R8 clamp flag",
                  VL'({illegal, sat}), VL'({1'b0, TBL[t].esat}));
        end

        // R7 R8: byte mode interleave with distinct elements, one clamping lane
        size_fld = 2'b01; imm_fld = 5'd31;
        for (int i = 0; i < 4; i++)
            for (int e = 0; e < VL / 32; e++) begin
                logic [31:0] v;
                v = 32'((4 * e + i) * 4 + 1);
                if (i == 2 && e == VL / 32 - 1) v = 32'h7FFFFFFF;
                case (i)
                    0: s0[e*32 +: 32] = v;
                    1: s1[e*32 +: 32] = v;
                    2: s2[e*32 +: 32] = v;
                    default: s3[e*32 +: 32] = v;
                endcase
            end
        expv = '0; es = 1'b0;
        for (int i = 0; i < 4; i++)
            for (int e = 0; e < VL / 32; e++) begin
                logic [31:0] v;
                case (i)
                    0: v = s0[e*32 +: 32];
                    1: v = s1[e*32 +: 32];
                    2: v = s2[e*32 +: 32];
                    default: v = s3[e*32 +: 32];
                endcase
                expv[(4*e+i)*8 +: 8] = model({{32{v[31]}}, v}, 1, 8, ls)[7:0];
                es |= ls;
            end
        apply();
        check(dst == expv, "R7 byte interleave order", dst, expv);
        check(sat == 1'b1 && es == 1'b1, "R8 single lane clamp", VL'(sat), VL'(1));

        // R7: halfword interleave, shift 33, no clamp
        size_fld = 2'b10; imm_fld = 5'd31;
        for (int i = 0; i < 4; i++)
            for (int e = 0; e < VL / 64; e++) begin
                logic [63:0] v;
                v = 64'((4 * e + i) + 1) << 33;
                case (i)
                    0: s0[e*64 +: 64] = v;
                    1: s1[e*64 +: 64] = v;
                    2: s2[e*64 +: 64] = v;
                    default: s3[e*64 +: 64] = v;
                endcase
                expv[(4*e+i)*16 +: 16] = model(v, 33, 16, ls);
            end
        apply();
        check(dst == expv && sat == 1'b0, "R7 halfword interleave order", dst, expv);

        // R1: reserved size field
        size_fld = 2'b00; imm_fld = 5'd7;
        fill_all(64'h7FFFFFFF7FFFFFFF, 1'b0);
        apply();
        check(illegal == 1'b1 && dst == '0 && sat == 1'b0, "R1 illegal zeroes",
              {dst[VL-3:0], illegal, sat}, VL'(2));

        // R9: hold and valid timing
        size_fld = 2'b11; imm_fld = 5'd31;
        fill_all(64'h3, 1'b1);
        apply();
        check(out_valid == 1'b1, "R9 valid one cycle later", VL'(out_valid), VL'(1));
        held = dst;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 valid drops", VL'(out_valid), VL'(0));
        size_fld = 2'b01; imm_fld = 5'd0;
        fill_all(64'h55555555, 1'b0);
        repeat (2) @(negedge clk);
        check(dst == held && illegal == 1'b0, "R9 hold without valid", dst, held);

        // R10: mid-run reset
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && dst == '0 && sat == 1'b0 && illegal == 1'b0,
              "R10 mid-run reset", dst, '0);
        rst = 1'b0;

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule